// File: doc/BRIEF.md
# Peripheral Access Protection Gate

This block sits on an APB-style bus between one upstream requester and a bank of downstream peripheral ports. Each access arrives with a one-hot port select from an external address decoder. During the setup phase the gate judges the access against the selected port's own configuration. It looks at two attributes carried in the protection field: whether the access is secure and whether it is privileged. An access that is permitted passes through to its port unchanged, and the port's response comes back to the requester.

An access that is refused never reaches any port. The gate answers it on its own in the first access-phase cycle. A global response-mode input chooses the kind of answer. In one mode the gate returns a slave error. In the other it returns an OK completion that reads zero and discards the write.

A compile-time mask can exempt chosen ports from the security comparison. The privilege comparison still applies to those ports. Refused accesses raise a sticky status flag, which drives one level interrupt output through an enable input. A clear input wipes the flag, and while the clear input is held high no refused access can set the flag.

Top module: `periph_guard`

## Requirements
- R1: For a port whose bypass-mask bit is 0, a secure access (PPROT[1]=0) is refused when the port's non-secure config bit is 1, and a non-secure access (PPROT[1]=1) is refused when that bit is 0.
- R2: For a port whose bypass-mask bit is 1, the secure/non-secure comparison is skipped entirely.
- R3: An unprivileged access (PPROT[0]=0) is refused when the port's unprivileged-allowed bit is 0, whatever the bypass mask says. A privileged access (PPROT[0]=1) is never refused for privilege.
- R4: A permitted access asserts the downstream select of exactly the selected port in both phases, and forwards enable, direction, address, write data and all three PPROT bits unchanged. It returns that port's read data, ready and error, including any wait states the port inserts.
- R5: A refused access asserts no downstream select in either phase. It completes with ready high in its first access-phase cycle.
- R6: A refused access with the response-mode input at 1 ends with PSLVERR=1 and zero read data.
- R7: A refused access with the response-mode input at 0 ends with PSLVERR=0. A read returns all-zero data, and a write is not delivered to any port.
- R8: The status flag is set at the clock edge that completes a refused access, provided the clear input is low. The flag stays set, and further permitted accesses do not clear it. The interrupt output equals the flag AND the enable input, and it follows the enable input within the same cycle.
- R9: The clear input at 1 empties the status flag on the next clock edge. Refused accesses that complete while the clear input is 1 leave the flag empty.
- R10: The configuration inputs are registered on every clock edge, and reset forces the registers to 0. A setup phase that starts in the cycle reset is released is judged with all configuration at 0. A configuration change governs accesses whose setup phase begins at least one cycle later.
- R11: During reset the status flag is 0, so the interrupt output is low even with the enable input high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_psel | input | 1 | Upstream select |
| up_penable | input | 1 | Upstream enable (access phase) |
| up_pwrite | input | 1 | Upstream direction, 1 = write |
| up_paddr | input | ADDR_W | Upstream address |
| up_pwdata | input | DATA_W | Upstream write data |
| up_pprot | input | 3 | Protection: bit1 = non-secure, bit0 = privileged |
| up_port_sel | input | NUM_PORTS | One-hot target port from the address decoder |
| up_prdata | output | DATA_W | Read data to the requester |
| up_pready | output | 1 | Ready to the requester |
| up_pslverr | output | 1 | Error to the requester |
| dn_psel | output | NUM_PORTS | Per-port downstream select |
| dn_penable | output | 1 | Shared downstream enable |
| dn_pwrite | output | 1 | Shared downstream direction |
| dn_paddr | output | ADDR_W | Shared downstream address |
| dn_pwdata | output | DATA_W | Shared downstream write data |
| dn_pprot | output | 3 | Shared downstream protection |
| dn_prdata | input | NUM_PORTS*DATA_W | Read data of all ports, port i at bits i*DATA_W upward |
| dn_pready | input | NUM_PORTS | Ready of each port |
| dn_pslverr | input | NUM_PORTS | Error of each port |
| cfg_nonsec | input | NUM_PORTS | Per port: 1 = port takes non-secure accesses |
| cfg_user_ok | input | NUM_PORTS | Per port: 1 = unprivileged accesses allowed |
| cfg_err_mode | input | 1 | 1 = refused access gives an error, 0 = silent completion |
| irq_enable | input | 1 | Interrupt enable |
| irq_clear | input | 1 | Clear the status flag; holding it high blocks setting |
| irq | output | 1 | Refused-access interrupt |

## Verification
The upstream response of a refused access is combinational in the first access-phase cycle. The bench therefore samples ready, error and data one nanosecond after the falling edge that raised the enable. It counts falling edges until ready appears, so the single wait state of the slow port is verified and a refused access must show none. The status flag rises on the rising edge that ends a refused access, so the interrupt is read after the following falling edge. An enable change is read one nanosecond later with no edge in between. A clear is read after the next edge. Configuration is changed on a falling edge and used from the next falling edge on. The one exception is the reset-release access, whose setup starts in the same cycle and must be judged against a cleared configuration.

// File: rtl/guard_pkg.sv
// Package: shared types for the peripheral access protection gate.
// Assumes APB-style two-phase transfers (setup, then one or more access cycles).
package guard_pkg;

    // Bus phase as seen by the gate
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } bus_phase_e;

    // Decode the phase from select and enable
    function automatic bus_phase_e phase_of(input logic sel, input logic en);
        if (!sel)     return PH_IDLE;
        else if (!en) return PH_SETUP;
        else          return PH_ACCESS;
    endfunction

endpackage

// File: rtl/guard_rules.sv
// Module: guard_rules
// Purpose: per-port access verdict. For the port named by the one-hot
// select it reports whether the access breaks the security rule (unless
// the port is in the bypass mask) or the privilege rule.
// Assumes: sel is one-hot or zero; zero select yields "not refused".
module guard_rules #(
    parameter int                 NUM_PORTS   = 16,
    parameter logic [NUM_PORTS-1:0] BYPASS_MASK = '0
) (
    input  logic [NUM_PORTS-1:0] sel,
    input  logic                 prot_nonsec,
    input  logic                 prot_priv,
    input  logic [NUM_PORTS-1:0] nonsec_q,
    input  logic [NUM_PORTS-1:0] user_ok_q,
    output logic                 refuse
);

    logic [NUM_PORTS-1:0] port_fail;

    // One verdict per port; the mask variant is fixed at elaboration
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        logic sec_fail;
        logic priv_fail;
        if (BYPASS_MASK[i]) begin : g_bypass
            assign sec_fail = 1'b0;
        end else begin : g_checked
            // secure access (prot_nonsec=0) must meet a port with nonsec=0
            assign sec_fail = (prot_nonsec != nonsec_q[i]);
        end
        assign priv_fail    = !prot_priv && !user_ok_q[i];
        assign port_fail[i] = sec_fail || priv_fail;
    end

    // Select the verdict of the addressed port
    always_comb begin
        refuse = |(sel & port_fail);
    end

endmodule

// File: rtl/guard_route.sv
// Module: guard_route
// Purpose: fans the upstream request out to the chosen port and muxes its
// response back; substitutes a local response for a refused access.
// Assumes: sel is one-hot; gate is the refusal for the current phase.
module guard_route #(
    parameter int NUM_PORTS = 16,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [DATA_W-1:0]           pwdata,
    input  logic [2:0]                  pprot,
    input  logic [NUM_PORTS-1:0]        sel,
    input  logic                        gate,
    input  logic                        local_resp,
    input  logic                        local_err,
    output logic [DATA_W-1:0]           prdata,
    output logic                        pready,
    output logic                        pslverr,
    output logic [NUM_PORTS-1:0]        dn_psel,
    output logic                        dn_penable,
    output logic                        dn_pwrite,
    output logic [ADDR_W-1:0]           dn_paddr,
    output logic [DATA_W-1:0]           dn_pwdata,
    output logic [2:0]                  dn_pprot,
    input  logic [NUM_PORTS*DATA_W-1:0] dn_prdata,
    input  logic [NUM_PORTS-1:0]        dn_pready,
    input  logic [NUM_PORTS-1:0]        dn_pslverr
);

    logic [DATA_W-1:0] mux_rdata;
    logic              mux_ready;
    logic              mux_err;

    // Per-port select, suppressed while the access is refused
    always_comb begin
        dn_psel = {NUM_PORTS{psel && !gate}} & sel;
    end

    // Shared request fields pass through untouched
    always_comb begin
        dn_penable = penable;
        dn_pwrite  = pwrite;
        dn_paddr   = paddr;
        dn_pwdata  = pwdata;
        dn_pprot   = pprot;
    end

    // AND-OR return mux over the one-hot select
    always_comb begin
        mux_rdata = '0;
        mux_ready = 1'b0;
        mux_err   = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel[i]) begin
                mux_rdata = mux_rdata | dn_prdata[i*DATA_W +: DATA_W];
                mux_ready = mux_ready | dn_pready[i];
                mux_err   = mux_err   | dn_pslverr[i];
            end
        end
    end

    // Choose between the port's answer and the gate's own answer
    always_comb begin
        if (local_resp) begin
            prdata  = '0;
            pready  = 1'b1;
            pslverr = local_err;
        end else begin
            prdata  = mux_rdata;
            pready  = mux_ready;
            pslverr = mux_err;
        end
    end

endmodule

// File: rtl/guard_irq.sv
// Module: guard_irq
// Purpose: sticky refused-access status flag and the gated interrupt.
// Assumes: hit is high for exactly the completing cycle of a refused access.
module guard_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic irq_clear,
    input  logic irq_enable,
    output logic irq
);

    logic stat_q;

    // Clear wins over set; a held clear keeps the flag from rising
    always_ff @(posedge clk) begin
        if (!rst_n)         stat_q <= 1'b0;
        else if (irq_clear) stat_q <= 1'b0;
        else if (hit)       stat_q <= 1'b1;
    end

    // Level output follows both flag and enable without delay
    always_comb begin
        irq = stat_q && irq_enable;
    end

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_enable |-> !irq);

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !irq_clear) |=> (irq || !irq_enable));

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |=> !irq);

endmodule

// File: rtl/periph_guard.sv
// Module: periph_guard (top)
// Purpose: APB-style protection gate in front of NUM_PORTS peripherals.
// Registers the configuration, judges each access at its setup edge,
// and either forwards it or answers it locally, flagging refusals.
// Assumes: up_port_sel is one-hot while up_psel is high, and stays
// stable for the whole transfer.
module periph_guard #(
    parameter int                   NUM_PORTS   = 16,
    parameter int                   ADDR_W      = 12,
    parameter int                   DATA_W      = 32,
    parameter logic [NUM_PORTS-1:0] BYPASS_MASK = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        up_psel,
    input  logic                        up_penable,
    input  logic                        up_pwrite,
    input  logic [ADDR_W-1:0]           up_paddr,
    input  logic [DATA_W-1:0]           up_pwdata,
    input  logic [2:0]                  up_pprot,
    input  logic [NUM_PORTS-1:0]        up_port_sel,
    output logic [DATA_W-1:0]           up_prdata,
    output logic                        up_pready,
    output logic                        up_pslverr,
    output logic [NUM_PORTS-1:0]        dn_psel,
    output logic                        dn_penable,
    output logic                        dn_pwrite,
    output logic [ADDR_W-1:0]           dn_paddr,
    output logic [DATA_W-1:0]           dn_pwdata,
    output logic [2:0]                  dn_pprot,
    input  logic [NUM_PORTS*DATA_W-1:0] dn_prdata,
    input  logic [NUM_PORTS-1:0]        dn_pready,
    input  logic [NUM_PORTS-1:0]        dn_pslverr,
    input  logic [NUM_PORTS-1:0]        cfg_nonsec,
    input  logic [NUM_PORTS-1:0]        cfg_user_ok,
    input  logic                        cfg_err_mode,
    input  logic                        irq_enable,
    input  logic                        irq_clear,
    output logic                        irq
);
    import guard_pkg::*;

    localparam int PROT_NS_BIT   = 1;
    localparam int PROT_PRIV_BIT = 0;

    bus_phase_e           phase;
    logic [NUM_PORTS-1:0] nonsec_q;
    logic [NUM_PORTS-1:0] user_ok_q;
    logic                 err_mode_q;
    logic                 refuse_now;
    logic                 refuse_q;
    logic                 err_lat_q;
    logic                 gate;
    logic                 local_resp;
    logic                 refused_done;

    // Decode which phase the upstream bus is in
    always_comb begin
        phase = phase_of(up_psel, up_penable);
    end

    // Configuration registers; reset returns every field to 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nonsec_q   <= '0;
            user_ok_q  <= '0;
            err_mode_q <= 1'b0;
        end else begin
            nonsec_q   <= cfg_nonsec;
            user_ok_q  <= cfg_user_ok;
            err_mode_q <= cfg_err_mode;
        end
    end

    guard_rules #(
        .NUM_PORTS   (NUM_PORTS),
        .BYPASS_MASK (BYPASS_MASK)
    ) u_rules (
        .sel         (up_port_sel),
        .prot_nonsec (up_pprot[PROT_NS_BIT]),
        .prot_priv   (up_pprot[PROT_PRIV_BIT]),
        .nonsec_q    (nonsec_q),
        .user_ok_q   (user_ok_q),
        .refuse      (refuse_now)
    );

    // Freeze the verdict and response mode at the setup edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refuse_q  <= 1'b0;
            err_lat_q <= 1'b0;
        end else if (phase == PH_SETUP) begin
            refuse_q  <= refuse_now;
            err_lat_q <= err_mode_q;
        end
    end

    // Refusal in force for the current phase, and local-answer strobe
    always_comb begin
        gate         = (phase == PH_SETUP) ? refuse_now : refuse_q;
        local_resp   = (phase == PH_ACCESS) && refuse_q;
        refused_done = local_resp;
    end

    guard_route #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_route (
        .psel       (up_psel),
        .penable    (up_penable),
        .pwrite     (up_pwrite),
        .paddr      (up_paddr),
        .pwdata     (up_pwdata),
        .pprot      (up_pprot),
        .sel        (up_port_sel),
        .gate       (gate),
        .local_resp (local_resp),
        .local_err  (err_lat_q),
        .prdata     (up_prdata),
        .pready     (up_pready),
        .pslverr    (up_pslverr),
        .dn_psel    (dn_psel),
        .dn_penable (dn_penable),
        .dn_pwrite  (dn_pwrite),
        .dn_paddr   (dn_paddr),
        .dn_pwdata  (dn_pwdata),
        .dn_pprot   (dn_pprot),
        .dn_prdata  (dn_prdata),
        .dn_pready  (dn_pready),
        .dn_pslverr (dn_pslverr)
    );

    guard_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (refused_done),
        .irq_clear  (irq_clear),
        .irq_enable (irq_enable),
        .irq        (irq)
    );

    // R5
    refused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACCESS && refuse_q) |-> (dn_psel == '0 && up_pready));

    // R4
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_psel));

    // R6
    err_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACCESS && refuse_q && err_lat_q)
            |-> (up_pslverr && up_prdata == '0));

    // R7
    silent_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACCESS && refuse_q && !err_lat_q)
            |-> (!up_pslverr && up_prdata == '0));

    // R11
    reset_irq_chk: assert property (@(posedge clk)
        !rst_n |=> !irq);

endmodule

// File: tb/tb_periph_guard.sv
// Bench: sweeps every port, every PPROT security/privilege pair, both
// directions and all uniform configuration combinations; then checks the
// reset-release access and the interrupt flag behaviour.
module tb_periph_guard;

    localparam int NP = 16;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam logic [NP-1:0] MASK = 16'h0005;
    localparam int SLOW_PORT = 7;
    localparam int ERR_PORT  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              up_psel = 1'b0, up_penable = 1'b0, up_pwrite = 1'b0;
    logic [AW-1:0]     up_paddr = '0;
    logic [DW-1:0]     up_pwdata = '0;
    logic [2:0]        up_pprot = '0;
    logic [NP-1:0]     up_port_sel = '0;
    logic [DW-1:0]     up_prdata;
    logic              up_pready, up_pslverr;
    logic [NP-1:0]     dn_psel;
    logic              dn_penable, dn_pwrite;
    logic [AW-1:0]     dn_paddr;
    logic [DW-1:0]     dn_pwdata;
    logic [2:0]        dn_pprot;
    logic [NP*DW-1:0]  dn_prdata;
    logic [NP-1:0]     dn_pready, dn_pslverr;
    logic [NP-1:0]     cfg_nonsec = '0, cfg_user_ok = '0;
    logic              cfg_err_mode = 1'b0;
    logic              irq_enable = 1'b0, irq_clear = 1'b0;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    periph_guard #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .BYPASS_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n),
        .up_psel(up_psel), .up_penable(up_penable), .up_pwrite(up_pwrite),
        .up_paddr(up_paddr), .up_pwdata(up_pwdata), .up_pprot(up_pprot),
        .up_port_sel(up_port_sel), .up_prdata(up_prdata), .up_pready(up_pready),
        .up_pslverr(up_pslverr), .dn_psel(dn_psel), .dn_penable(dn_penable),
        .dn_pwrite(dn_pwrite), .dn_paddr(dn_paddr), .dn_pwdata(dn_pwdata),
        .dn_pprot(dn_pprot), .dn_prdata(dn_prdata), .dn_pready(dn_pready),
        .dn_pslverr(dn_pslverr), .cfg_nonsec(cfg_nonsec), .cfg_user_ok(cfg_user_ok),
        .cfg_err_mode(cfg_err_mode), .irq_enable(irq_enable), .irq_clear(irq_clear),
        .irq(irq)
    );

    // Downstream models: fixed data pattern, one slow port, one erroring port
    logic slow_w = 1'b0;
    always @(posedge clk) slow_w <= dn_psel[SLOW_PORT] & dn_penable & ~slow_w;

    for (genvar g = 0; g < NP; g++) begin : g_dn
        assign dn_prdata[g*DW +: DW] = 32'hC0DE_0000 | (32'(g) << 8) | 32'(dn_paddr[7:0]);
        assign dn_pready[g]  = (g == SLOW_PORT) ? slow_w : 1'b1;
        assign dn_pslverr[g] = (g == ERR_PORT);
    end

    // Monitor of downstream activity
    logic           touched = 1'b0, wr_hit = 1'b0;
    logic [DW-1:0]  wr_data = '0;
    logic [AW-1:0]  wr_addr = '0;
    logic [2:0]     wr_prot = '0;
    always @(posedge clk) begin
        if (|dn_psel) touched <= 1'b1;
        if (|(dn_psel & dn_pready) && dn_penable && dn_pwrite) begin
            wr_hit  <= 1'b1;
            wr_data <= dn_pwdata;
            wr_addr <= dn_paddr;
            wr_prot <= dn_pprot;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One transfer; called on a falling edge, returns on a falling edge
    task automatic xfer(input int p, input logic wr, input logic [2:0] prot,
                        input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output logic err, output int waits);
        touched     = 1'b0;
        wr_hit      = 1'b0;
        up_psel     = 1'b1;
        up_penable  = 1'b0;
        up_pwrite   = wr;
        up_pprot    = prot;
        up_paddr    = addr;
        up_pwdata   = wd;
        up_port_sel = NP'(1) << p;
        @(negedge clk);
        up_penable = 1'b1;
        waits = 0;
        #1;
        while (!up_pready && waits < 8) begin
            waits++;
            @(negedge clk);
            #1;
        end
        rd  = up_prdata;
        err = up_pslverr;
        @(negedge clk);
        up_psel    = 1'b0;
        up_penable = 1'b0;
    endtask

    logic [DW-1:0] rd;
    logic          err;
    int            waits;

    initial begin : main
        // Reset state: config inputs all high while reset holds
        cfg_nonsec   = '1;
        cfg_user_ok  = '1;
        cfg_err_mode = 1'b1;
        irq_enable   = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(irq == 1'b0, "R11 irq low in reset", 32'(irq), 0);
        chk(dn_psel == '0, "R11 no select in reset", 32'(dn_psel), 0);
        @(negedge clk);
        // Setup in the release cycle: judged with config 0 (unpriv secure read)
        rst_n = 1'b1;
        xfer(1, 1'b0, 3'b000, 12'h010, '0, rd, err, waits);
        chk(err == 1'b0, "R10 release access uses zero config (err mode 0)", 32'(err), 0);
        chk(!touched, "R10 release access refused by privilege", 32'(touched), 0);
        chk(rd == '0, "R10 release access reads zero", rd, 0);
        // Now registered config is all ones: secure to non-secure port, error mode
        xfer(1, 1'b0, 3'b000, 12'h010, '0, rd, err, waits);
        chk(err == 1'b1, "R10 config applied after release", 32'(err), 1);

        // Hold clear through the sweep
        irq_clear = 1'b1;

        for (int ns = 0; ns < 2; ns++)
        for (int up = 0; up < 2; up++)
        for (int er = 0; er < 2; er++) begin
            cfg_nonsec   = {NP{ns[0]}};
            cfg_user_ok  = {NP{up[0]}};
            cfg_err_mode = er[0];
            @(negedge clk);
            for (int p = 0; p < NP; p++)
            for (int pr = 0; pr < 4; pr++)
            for (int w = 0; w < 2; w++) begin
                logic [2:0]    prot;
                logic [AW-1:0] addr;
                logic [DW-1:0] wd;
                logic          is_sec, is_user, sec_bad, priv_bad, exp_ref;
                string         dtag;
                prot     = {logic'(p[0]), logic'(pr[1]), logic'(pr[0])};
                addr     = AW'(p * 16 + pr * 4 + w);
                wd       = 32'h5A00_0000 | 32'(p << 8) | 32'(pr << 4) | 32'(w);
                is_sec   = !prot[1];
                is_user  = !prot[0];
                sec_bad  = (is_sec == ns[0]) && !MASK[p];
                priv_bad = is_user && !up[0];
                exp_ref  = sec_bad || priv_bad;
                dtag     = priv_bad ? "R3 privilege verdict" :
                           (MASK[p] ? "R2 bypassed verdict" : "R1 security verdict");
                xfer(p, w[0], prot, addr, wd, rd, err, waits);
                chk(touched == !exp_ref, dtag, 32'(touched), 32'(!exp_ref));
                if (exp_ref) begin
                    chk(waits == 0, "R5 refused completes at once", 32'(waits), 0);
                    chk(err == er[0], er[0] ? "R6 error answer" : "R7 silent answer",
                        32'(err), 32'(er));
                    if (w == 0)
                        chk(rd == '0, er[0] ? "R6 zero data" : "R7 zero data", rd, 0);
                    else
                        chk(!wr_hit, "R7 write dropped", 32'(wr_hit), 0);
                end else begin
                    chk(waits == ((p == SLOW_PORT) ? 1 : 0), "R4 wait states passed",
                        32'(waits), 32'(p == SLOW_PORT));
                    chk(err == (p == ERR_PORT), "R4 port error passed", 32'(err),
                        32'(p == ERR_PORT));
                    if (w == 0) begin
                        logic [DW-1:0] exp_rd;
                        exp_rd = 32'hC0DE_0000 | 32'(p << 8) | 32'(addr[7:0]);
                        chk(rd == exp_rd, "R4 read data", rd, exp_rd);
                    end else begin
                        chk(wr_hit && wr_data == wd && wr_addr == addr && wr_prot == prot,
                            "R4 write forwarded", wr_data, wd);
                    end
                end
            end
        end

        // Many refusals under a held clear left no flag
        irq_clear = 1'b0;
        @(negedge clk);
        #1;
        chk(irq == 1'b0, "R9 held clear kept flag empty", 32'(irq), 0);
        @(negedge clk);

        // Non-secure privileged to secure port 4: refused
        cfg_nonsec   = '0;
        cfg_user_ok  = '1;
        cfg_err_mode = 1'b0;
        @(negedge clk);
        xfer(4, 1'b0, 3'b011, 12'h040, '0, rd, err, waits);
        #1;
        chk(irq == 1'b1, "R8 refusal raises irq", 32'(irq), 1);
        @(negedge clk);
        xfer(4, 1'b0, 3'b001, 12'h044, '0, rd, err, waits);
        #1;
        chk(irq == 1'b1, "R8 flag sticky over permitted access", 32'(irq), 1);
        irq_enable = 1'b0;
        #1;
        chk(irq == 1'b0, "R8 enable low masks irq", 32'(irq), 0);
        irq_enable = 1'b1;
        #1;
        chk(irq == 1'b1, "R8 enable high shows flag", 32'(irq), 1);
        @(negedge clk);
        irq_clear = 1'b1;
        #1;
        chk(irq == 1'b1, "R9 clear acts on the edge", 32'(irq), 1);
        @(negedge clk);
        #1;
        chk(irq == 1'b0, "R9 clear empties flag", 32'(irq), 0);
        irq_clear = 1'b0;
        @(negedge clk);
        #1;
        chk(irq == 1'b0, "R9 flag stays empty after clear", 32'(irq), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule